// File: doc/BRIEF.md
# Memory-to-Memory Multicycle CPU Core

This core executes a small instruction set in which every operand and every result lives in one shared, word-addressed memory; there is no register file. A single-port synchronous memory with one cycle of read latency holds both the program and the 32-bit data words. Each 32-bit instruction holds a 3-bit operation code, an immediate-select bit and two 14-bit address fields, called A and B here. The core steps through the instruction one memory access per cycle. It fetches the word at the program counter and reads the word at A. It then reads the word at B, and for the indirect copy it reads once more through that word as a pointer. After that it computes and writes the result.

The A field always names the destination word (or, in one copy form, the word that holds the destination address). The select bit picks between the memory word at B and the zero-extended 14-bit value B itself as the second operand. Branches take their targets from memory, so jump tables and computed returns need no extra instructions. All arithmetic is in a separate combinational ALU. The sequencer is a small state machine.

Top module: `mmcpu_core`

## Requirements
- R1: While rst_n is low at a rising edge, the program counter is set to 0 and the core returns to the fetch step. mem_we is 0 during reset, and the first cycle after reset drives mem_addr = 0.
- R2: Each instruction starts with a fetch cycle that drives the program counter on mem_addr. A non-branch instruction leaves the counter at its own address plus one. Every instruction except the indirect-read copy takes 5 cycles (fetch, read A, read B, execute, write-back).
- R3: Operation code 0 stores mem[A] + operand2, modulo 2^32, into mem[A]. Operand2 is mem[B] when bit 28 (the select bit) is 0, and B zero-extended to 32 bits when it is 1. The code sits in bits 31:29, A in bits 27:14 and B in bits 13:0.
- R4: Operation code 7 stores the low 32 bits of mem[A] * operand2 into mem[A].
- R5: Operation code 1 stores ~(mem[A] & operand2) into mem[A].
- R6: Operation code 2 stores mem[A] >> operand2 when operand2 < 32. Otherwise it stores mem[A] << (operand2 - 32), and a result shifted out completely is 0.
- R7: Operation code 3 stores 1 into mem[A] when mem[A] < operand2 (unsigned), and 0 otherwise.
- R8: Operation code 4 stores operand2 into mem[A].
- R9: Operation code 5 with select 0 stores mem[mem[B]] into mem[A], using the low 14 bits of mem[B] as the address. This form takes 6 cycles.
- R10: Operation code 5 with select 1 stores mem[B] into the word whose address is the low 14 bits of mem[A].
- R11: Operation code 6 with select 0 writes no memory. The next fetch is at mem[A] when mem[B] is zero, and at the instruction address plus one otherwise.
- R12: Operation code 6 with select 1 writes no memory, and the next fetch is at the low 14 bits of mem[A] + B.
- R13: mem_we is high only in the last cycle of an instruction that writes memory, and at most once per instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 14 | Word address for the read or write this cycle |
| mem_wdata | output | 32 | Data written when mem_we is high |
| mem_we | output | 1 | Write strobe for the current cycle |
| mem_rdata | input | 32 | Word addressed in the previous cycle |

## Verification
A test program runs every operation in both select forms. Its operand values are chosen to separate the branches inside each one. An immediate with all 14 bits set shows zero extension against sign extension. Shift amounts of 4, 31, 36 and 64 cover the right-shift side, the left-shift side and a left shift that clears the word. A multiply of 7 by 16383 exposes a truncated product. A taken and a not-taken conditional branch, each with a skipped write behind it, show whether the condition is read from B or from A. A jump of pointer plus offset shows whether the offset is added. The indirect copy forms point at words that differ from the pointer value, so a core that skips the extra indirection writes a value that can be told apart. Every clock is compared with a behavioural model, so any drift of the cycle count shows up as a wrong fetch address.

// File: rtl/mmcpu_pkg.sv
// Shared types for the memory-to-memory core: operation codes and the
// sequencer states. Field layout constants assume a 32-bit instruction
// word split as 3 + 1 + 14 + 14 bits.
package mmcpu_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_NAND = 3'd1,
        OP_SHF  = 3'd2,
        OP_LT   = 3'd3,
        OP_CPY  = 3'd4,
        OP_IND  = 3'd5,
        OP_BR   = 3'd6,
        OP_MUL  = 3'd7
    } op_e;

    typedef enum logic [2:0] {
        S_FETCH = 3'd0,
        S_RDA   = 3'd1,
        S_RDB   = 3'd2,
        S_RDI   = 3'd3,
        S_EXE   = 3'd4,
        S_WB    = 3'd5
    } st_e;

endpackage

// File: rtl/mmcpu_alu.sv
// Combinational ALU. Computes the value to store for every operation
// code and, for branches, whether the branch is taken. For branches y
// carries the target (mem[A], or mem[A] + B for the unconditional form).
// Assumes b is already the selected second operand.
module mmcpu_alu
    import mmcpu_pkg::*;
#(
    parameter int DW = 32
) (
    input  op_e           op,
    input  logic          imm_sel,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] y,
    output logic          take
);

    localparam logic [DW-1:0] SHLIM = DW;

    // Result and branch decision for the decoded operation.
    always_comb begin
        y    = '0;
        take = 1'b0;
        unique case (op)
            OP_ADD:  y = a + b;
            OP_NAND: y = ~(a & b);
            OP_SHF:  y = (b < SHLIM) ? (a >> b) : (a << (b - SHLIM));
            OP_LT:   y = {{(DW-1){1'b0}}, (a < b)};
            OP_CPY:  y = b;
            OP_IND:  y = b;
            OP_BR: begin
                y    = imm_sel ? (a + b) : a;
                take = imm_sel | (b == '0);
            end
            OP_MUL:  y = a * b;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/mmcpu_seq.sv
// Control sequencer. One memory access per state; the indirect read
// state is entered only for the pointer-read copy. Assumes memory read
// data appears one cycle after the address.
module mmcpu_seq
    import mmcpu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  op_e  op,
    input  logic imm_sel,
    output st_e  state
);

    st_e nxt;

    // Next step of the instruction.
    always_comb begin
        unique case (state)
            S_FETCH: nxt = S_RDA;
            S_RDA:   nxt = S_RDB;
            S_RDB:   nxt = (op == OP_IND && !imm_sel) ? S_RDI : S_EXE;
            S_RDI:   nxt = S_EXE;
            S_EXE:   nxt = S_WB;
            S_WB:    nxt = S_FETCH;
            default: nxt = S_FETCH;
        endcase
    end

    // State register with synchronous reset to fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_FETCH;
        else        state <= nxt;
    end

    // R9: the pointer-read copy always passes through the indirect read
    p_ind_path_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RDB && op == OP_IND && !imm_sel) |=> state == S_RDI);

    // R2: every other instruction goes straight to execute
    p_direct_path_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RDB && !(op == OP_IND && !imm_sel)) |=> state == S_EXE);

endmodule

// File: rtl/mmcpu_core.sv
// Memory-to-memory multicycle CPU core. Owns the program counter, the
// instruction register and the operand/result registers, and steers the
// single memory port. Assumes AW equals the 14-bit address field width
// and a one-cycle synchronous read.
module mmcpu_core
    import mmcpu_pkg::*;
#(
    parameter int DW = 32,
    parameter int AW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    input  logic [DW-1:0] mem_rdata
);

    localparam int FW  = (DW - 4) / 2;
    localparam int BLO = 0;
    localparam int ALO = FW;
    localparam int IPOS = 2 * FW;
    localparam int OLO = 2 * FW + 1;

    st_e           state;
    logic [DW-1:0] ir_r;
    logic [DW-1:0] opa_r;
    logic [DW-1:0] res_r;
    logic          take_r;
    logic [AW-1:0] pc_r;
    op_e           op;
    logic          isel;
    logic [FW-1:0] fa;
    logic [FW-1:0] fb;
    logic [FW-1:0] rda_fa;
    logic [DW-1:0] opnd2;
    logic [DW-1:0] alu_y;
    logic          alu_take;

    assign op     = op_e'(ir_r[DW-1:OLO]);
    assign isel   = ir_r[IPOS];
    assign fa     = ir_r[ALO +: FW];
    assign fb     = ir_r[BLO +: FW];
    assign rda_fa = mem_rdata[ALO +: FW];

    mmcpu_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .op      (op),
        .imm_sel (isel),
        .state   (state)
    );

    // Second operand: zero-extended immediate or the word just read.
    assign opnd2 = (isel && op != OP_IND) ? {{(DW-FW){1'b0}}, fb} : mem_rdata;

    mmcpu_alu #(.DW(DW)) u_alu (
        .op      (op),
        .imm_sel (isel),
        .a       (opa_r),
        .b       (opnd2),
        .y       (alu_y),
        .take    (alu_take)
    );

    // Memory port steering for each step.
    always_comb begin
        mem_addr  = pc_r;
        mem_we    = 1'b0;
        mem_wdata = res_r;
        unique case (state)
            S_FETCH: mem_addr = pc_r;
            S_RDA:   mem_addr = AW'(rda_fa);
            S_RDB:   mem_addr = AW'(fb);
            S_RDI:   mem_addr = mem_rdata[AW-1:0];
            S_EXE:   mem_addr = AW'(fa);
            S_WB: begin
                mem_addr = (op == OP_IND && isel) ? opa_r[AW-1:0] : AW'(fa);
                mem_we   = (op != OP_BR);
            end
            default: mem_addr = pc_r;
        endcase
    end

    // Capture instruction, first operand and result as they become valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_r   <= '0;
            opa_r  <= '0;
            res_r  <= '0;
            take_r <= 1'b0;
        end else begin
            if (state == S_RDA) ir_r  <= mem_rdata;
            if (state == S_RDB) opa_r <= mem_rdata;
            if (state == S_EXE) begin
                res_r  <= alu_y;
                take_r <= alu_take;
            end
        end
    end

    // Program counter: advance or branch at write-back.
    always_ff @(posedge clk) begin
        if (!rst_n)             pc_r <= '0;
        else if (state == S_WB) pc_r <= take_r ? res_r[AW-1:0] : pc_r + 1'b1;
    end

    // R1: reset returns the counter to zero
    p_reset_pc_r1: assert property (@(posedge clk)
        !rst_n |=> (pc_r == '0 && state == S_FETCH));

    // R2: non-branch instructions advance by one word
    p_pc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WB && op != OP_BR) |=> pc_r == AW'($past(pc_r) + 1'b1));

    // R11: a conditional branch with zero condition goes to mem[A]
    p_bz_target_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_EXE && op == OP_BR && !isel && mem_rdata == '0)
        |=> ##1 pc_r == $past(opa_r[AW-1:0], 2));

    // R13: no write outside write-back, and none for branches
    p_write_slot_r13: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (state == S_WB && op != OP_BR));

    // R13: the counter is stable while an instruction is in flight
    p_pc_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_WB) |=> $stable(pc_r));

endmodule

// File: tb/mmcpu_core_test.sv
`timescale 1ns/1ps
module mmcpu_core_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_we;
    logic [31:0] mem_rdata = '0;

    logic [31:0] dmem [0:16383];
    logic [31:0] rmem [0:16383];

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    mmcpu_core uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata)
    );

    // Synchronous memory, one cycle read latency.
    always @(posedge clk) begin
        if (mem_we) dmem[mem_addr] <= mem_wdata;
        mem_rdata <= dmem[mem_addr];
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(input int op, input int i, input int a, input int b);
        return {op[2:0], i[0], a[13:0], b[13:0]};
    endfunction

    function automatic string rtag(input logic [2:0] op, input logic i);
        case (op)
            3'd0: return "R3 add";
            3'd1: return "R5 nand";
            3'd2: return "R6 shift";
            3'd3: return "R7 less-than";
            3'd4: return "R8 copy";
            3'd5: return i ? "R10 store via pointer" : "R9 load via pointer";
            3'd6: return i ? "R12 jump" : "R11 branch";
            default: return "R4 multiply";
        endcase
    endfunction

    task automatic put(input int ad, input logic [31:0] v);
        dmem[ad] = v;
        rmem[ad] = v;
    endtask

    initial begin
        int          phase;
        int          len;
        int          halts;
        bit          exp_we;
        logic [13:0] exp_wa;
        logic [31:0] exp_wd;
        logic [13:0] pc;
        logic [2:0]  cop;
        logic        ci;
        logic [2:0]  wop;
        logic        wi;

        for (int k = 0; k < 16384; k++) begin
            dmem[k] = '0;
            rmem[k] = '0;
        end
        put(0,  enc(4,1,100,5));
        put(1,  enc(4,1,101,7));
        put(2,  enc(0,0,100,101));
        put(3,  enc(0,1,100,3));
        put(4,  enc(7,0,100,101));
        put(5,  enc(7,1,101,16383));
        put(6,  enc(1,0,102,103));
        put(7,  enc(1,1,102,16'h3FFF));
        put(8,  enc(2,1,104,4));
        put(9,  enc(2,1,105,36));
        put(10, enc(2,0,106,107));
        put(11, enc(2,0,108,109));
        put(12, enc(3,0,110,111));
        put(13, enc(3,1,112,5));
        put(14, enc(4,0,113,100));
        put(15, enc(5,0,114,115));
        put(16, enc(5,1,117,118));
        put(17, enc(6,0,120,121));
        put(18, enc(4,1,122,1));
        put(19, enc(4,1,122,2));
        put(20, enc(6,0,123,124));
        put(21, enc(0,1,125,1));
        put(22, enc(6,1,126,3));
        put(23, enc(6,1,127,0));
        put(102, 32'hF0F0F0F0);
        put(103, 32'hFF00FF00);
        put(104, 32'h80000001);
        put(105, 32'h80000001);
        put(106, 32'hFFFFFFFF);
        put(107, 31);
        put(108, 32'hFFFFFFFF);
        put(109, 64);
        put(110, 3);
        put(111, 4);
        put(112, 5);
        put(115, 116);
        put(116, 32'hDEADBEEF);
        put(117, 119);
        put(118, 32'h12345678);
        put(120, 20);
        put(121, 0);
        put(123, 0);
        put(124, 1);
        put(126, 20);
        put(127, 23);

        // Reset phase (R1)
        repeat (3) begin
            @(negedge clk);
            chk(mem_we == 1'b0, "R1 no write in reset", {31'b0, mem_we}, 32'h0);
        end
        rst_n = 1'b1;
        chk(mem_addr == 14'd0, "R1 first fetch address", {18'b0, mem_addr}, 32'h0);

        pc = '0; phase = 0; len = 5; halts = 0;
        exp_we = 1'b0; exp_wa = '0; exp_wd = '0; wop = '0; wi = 1'b0;
        for (int cyc = 0; cyc < 5000; cyc++) begin
            if (phase == 0) begin
                logic [31:0] ins, a, b2, mb;
                logic [13:0] fa, fb;
                chk(mem_addr == pc, "R2 fetch address", {18'b0, mem_addr}, {18'b0, pc});
                chk(mem_we == 1'b0, "R13 no write at fetch", {31'b0, mem_we}, 32'h0);
                if (pc == 14'd23) halts++;
                if (halts == 3) break;
                ins = rmem[pc];
                cop = ins[31:29]; ci = ins[28]; fa = ins[27:14]; fb = ins[13:0];
                a  = rmem[fa];
                mb = rmem[fb];
                b2 = ci ? {18'b0, fb} : mb;
                len = (cop == 3'd5 && !ci) ? 6 : 5;
                exp_we = (cop != 3'd6);
                exp_wa = fa;
                wop = cop; wi = ci;
                case (cop)
                    3'd0: exp_wd = a + b2;
                    3'd1: exp_wd = ~(a & b2);
                    3'd2: exp_wd = (b2 < 32) ? (a >> b2) : (a << (b2 - 32));
                    3'd3: exp_wd = (a < b2) ? 32'd1 : 32'd0;
                    3'd4: exp_wd = b2;
                    3'd5: begin
                        if (ci) begin exp_wa = a[13:0]; exp_wd = mb; end
                        else    exp_wd = rmem[mb[13:0]];
                    end
                    3'd7: exp_wd = a * b2;
                    default: exp_wd = '0;
                endcase
                if (exp_we) begin
                    rmem[exp_wa] = exp_wd;
                    pc = pc + 1'b1;
                end else if (ci) begin
                    logic [31:0] t;
                    t = a + {18'b0, fb};
                    pc = t[13:0];
                end else begin
                    pc = (mb == 0) ? a[13:0] : pc + 1'b1;
                end
            end else if (phase == len - 1) begin
                chk(mem_we == exp_we, {rtag(wop, wi), " write strobe"}, {31'b0, mem_we}, {31'b0, exp_we});
                if (exp_we && mem_we) begin
                    chk(mem_addr == exp_wa, {rtag(wop, wi), " write address"}, {18'b0, mem_addr}, {18'b0, exp_wa});
                    chk(mem_wdata == exp_wd, {rtag(wop, wi), " write data"}, mem_wdata, exp_wd);
                end
            end else begin
                chk(mem_we == 1'b0, "R13 no write mid-instruction", {31'b0, mem_we}, 32'h0);
            end
            phase = (phase == len - 1) ? 0 : phase + 1;
            @(negedge clk);
        end
        if (halts != 3) chk(1'b0, "R2 watchdog: program did not reach its halt loop", 32'h0, 32'h1);

        // Hand-derived final values.
        chk(dmem[113] == 32'd105, "R8 copy of accumulated sum", dmem[113], 32'd105);
        chk(dmem[100] == 32'd105, "R3 add then R4 multiply", dmem[100], 32'd105);
        chk(dmem[101] == 32'd114681, "R4 multiply by full immediate", dmem[101], 32'd114681);
        chk(dmem[102] == 32'hFFFFF000, "R5 nand zero-extended immediate", dmem[102], 32'hFFFFF000);
        chk(dmem[104] == 32'h08000000, "R6 right shift", dmem[104], 32'h08000000);
        chk(dmem[105] == 32'h00000010, "R6 left shift above 31", dmem[105], 32'h00000010);
        chk(dmem[106] == 32'h00000001, "R6 right shift by 31", dmem[106], 32'h1);
        chk(dmem[108] == 32'h0, "R6 left shift by 32 clears", dmem[108], 32'h0);
        chk(dmem[110] == 32'd1, "R7 less-than true", dmem[110], 32'd1);
        chk(dmem[112] == 32'd0, "R7 less-than false", dmem[112], 32'd0);
        chk(dmem[114] == 32'hDEADBEEF, "R9 load via pointer", dmem[114], 32'hDEADBEEF);
        chk(dmem[119] == 32'h12345678, "R10 store via pointer", dmem[119], 32'h12345678);
        chk(dmem[117] == 32'd119, "R10 pointer word kept", dmem[117], 32'd119);
        chk(dmem[122] == 32'd0, "R11 taken branch skips writes", dmem[122], 32'd0);
        chk(dmem[125] == 32'd1, "R12 jump offset lands past counter", dmem[125], 32'd1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule